// File: doc/BRIEF.md
# Multichannel Oversampled Serial Receiver

This block receives a group of asynchronous serial lines that all run at the same baud rate. It has no timer for each line. A single free-running sample tick is shared by all lines, and its rate is a fixed integer multiple of the bit rate. On every tick, all lines are latched together in one register. Each line has its own small decoder that reads these samples.

Each decoder waits for an idle run followed by a low sample. It then counts ticks from that first low sample and reads each bit near its middle. It collects one 8-N-1 character and then starts hunting again. The tick counter restarts from zero for every character, so timing error between sender and receiver only builds up over one frame.

For each line, the block delivers:
- the received byte,
- a strobe one clock wide,
- a flag for a bad stop bit,
- an optional flag for disagreement around the bit centre.

Top module: `mcurx_top`

## Requirements
- R1: All lines pass through a two-flop synchroniser and are then latched together on the same tick. Identical frames sent on every line at the same moment are delivered on every line in the same clock cycle.
- R2: After reset every decoder is hunting with its idle count at zero. A low sample starts a frame only if at least IDLE_RUN consecutive high samples came before it (IDLE_RUN is 3 by default).
- R3: The first low sample is tick 1 of the start bit. Each bit is read at tick (OSR+1)/2 of its bit period, using integer division, and each bit period is OSR ticks long. The eight data bits arrive least significant bit first, and data bit 0 of the byte is the first bit after the start bit.
- R4: If the centre sample of the start bit is high, no byte is produced. The decoder returns to hunting with its idle count cleared.
- R5: The valid strobe is high for exactly one clock. It rises two clock cycles after the clock in which the tick that reads the stop-bit centre is asserted (capture register plus decoder register). The data bus holds its value until the next strobe.
- R6: If the stop-bit centre sample is low, the byte is still delivered and the framing flag is 1 during the strobe. The decoder then accepts no new start until it has seen a high sample. The framing flag is 0 whenever the strobe is low.
- R7: When voting is enabled, the samples one tick before and one tick after the centre are compared for the start bit and for each data bit. Any mismatch sets the noise flag during the strobe. The stop bit is excluded from this check. The noise flag is 0 whenever the strobe is low.
- R8: A good stop bit counts as a full idle run. A start bit that begins right after the stop-bit period is therefore accepted.
- R9: During and after reset, all strobes and flags are 0 and all data buses are 0.
- R10: Frames separated by idle gaps of any number of ticks, including gaps that are not a multiple of OSR, decode correctly, because each frame re-phases its own tick counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Shared oversample tick, one clock wide, at OSR times the bit rate |
| rx_i | input | NUM_CH | Serial lines; idle is high |
| rx_data_o | output | NUM_CH*8 | Received bytes; line n uses bits [8n+7:8n] |
| rx_valid_o | output | NUM_CH | One-clock strobe per line when a byte is delivered |
| rx_ferr_o | output | NUM_CH | Stop bit was low; valid only with the strobe |
| rx_noise_o | output | NUM_CH | Samples around a centre disagreed; valid only with the strobe |

## Verification
A wrong tick counter or bit index in a decoder shows up within one frame as one of the following:
- a shifted or bit-reversed byte,
- a strobe on the wrong clock,
- a missing byte.

The bench ties each strobe to the exact tick that carried the stop-bit centre. A decoder stuck in the wrong hunting state either drops the next character or produces a byte out of a glitch or a long low level. These cases show at the ports within about ten bit periods. Noise and framing flags are checked only against frames built to carry them, so a flag that fires spuriously is reported at the strobe where it appears.

// File: rtl/mcurx_pkg.sv
package mcurx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_FRAME  = 2'd1,
    ST_WAITHI = 2'd2
  } ch_state_e;

  localparam int BYTE_W   = 8;
  localparam int BIT_IDXW = 4;

endpackage

// File: rtl/mcurx_rst_sync.sv
module mcurx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= 2'b00;
    else         pipe_q <= {pipe_q[0], 1'b1};
  end

  assign rst_n_o = pipe_q[1];
endmodule

// File: rtl/mcurx_in_sync.sv
module mcurx_in_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  // lines reset to idle-high so no false start is seen after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/mcurx_capture.sv
module mcurx_capture #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] samp_o,
  output logic         samp_vld_o
);
  logic [W-1:0] samp_q, samp_d;
  logic         vld_q;

  always_comb begin
    samp_d = samp_q;
    if (tick_i) samp_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '1;
      vld_q  <= 1'b0;
    end else begin
      samp_q <= samp_d;
      vld_q  <= tick_i;
    end
  end

  assign samp_o     = samp_q;
  assign samp_vld_o = vld_q;

  // R1: all lanes move together only on a tick
  p_capture_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(samp_q));
  p_strobe_follows_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> vld_q);
endmodule

// File: rtl/mcurx_chan.sv
module mcurx_chan
  import mcurx_pkg::*;
#(
  parameter int OSR      = 4,
  parameter int IDLE_RUN = 3,
  parameter bit VOTE_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_vld_i,
  input  logic              samp_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              ferr_o,
  output logic              noise_o
);
  localparam int TW  = $clog2(OSR + 1);
  localparam int IW  = $clog2(IDLE_RUN + 1);
  localparam int CTR = (OSR + 1) / 2;
  localparam logic [TW-1:0] T_ONE  = TW'(1);
  localparam logic [TW-1:0] T_OSR  = TW'(OSR);
  localparam logic [TW-1:0] T_CTR  = TW'(CTR);
  localparam logic [TW-1:0] T_PRE  = TW'(CTR - 1);
  localparam logic [TW-1:0] T_POST = TW'(CTR + 1);
  localparam logic [IW-1:0] I_FULL = IW'(IDLE_RUN);
  localparam logic [IW-1:0] I_ONE  = IW'(1);
  localparam logic [BIT_IDXW-1:0] B_LASTDATA = BIT_IDXW'(8);

  ch_state_e             state_q, state_d;
  logic [IW-1:0]         idle_q, idle_d;
  logic [TW-1:0]         tcnt_q, tcnt_d, tcnt_n;
  logic [BIT_IDXW-1:0]   bidx_q, bidx_d, bidx_n;
  logic [BYTE_W-1:0]     shft_q, shft_d;
  logic [BYTE_W-1:0]     data_q, data_d;
  logic                  pre_q, pre_d;
  logic                  nacc_q, nacc_d;
  logic                  valid_q, valid_d;
  logic                  ferr_q, ferr_d;
  logic                  noise_q, noise_d;

  always_comb begin
    state_d = state_q;
    idle_d  = idle_q;
    tcnt_d  = tcnt_q;
    bidx_d  = bidx_q;
    shft_d  = shft_q;
    data_d  = data_q;
    pre_d   = pre_q;
    nacc_d  = nacc_q;
    valid_d = 1'b0;
    ferr_d  = 1'b0;
    noise_d = 1'b0;
    tcnt_n  = (tcnt_q == T_OSR) ? T_ONE : tcnt_q + T_ONE;
    bidx_n  = (tcnt_q == T_OSR) ? bidx_q + 1'b1 : bidx_q;

    if (samp_vld_i) begin
      unique case (state_q)
        ST_HUNT: begin
          if (samp_i) begin
            if (idle_q != I_FULL) idle_d = idle_q + I_ONE;
          end else if (idle_q == I_FULL) begin
            state_d = ST_FRAME;
            tcnt_d  = T_ONE;
            bidx_d  = '0;
            nacc_d  = 1'b0;
            idle_d  = '0;
            if (T_PRE == T_ONE) pre_d = samp_i;
          end else begin
            idle_d = '0;
          end
        end
        ST_FRAME: begin
          tcnt_d = tcnt_n;
          bidx_d = bidx_n;
          if (tcnt_n == T_PRE) pre_d = samp_i;
          if (VOTE_EN && tcnt_n == T_POST && bidx_n <= B_LASTDATA && samp_i != pre_q)
            nacc_d = 1'b1;
          if (tcnt_n == T_CTR) begin
            if (bidx_n == '0) begin
              if (samp_i) begin
                state_d = ST_HUNT;
                idle_d  = '0;
              end
            end else if (bidx_n <= B_LASTDATA) begin
              shft_d = {samp_i, shft_q[BYTE_W-1:1]};
            end else begin
              valid_d = 1'b1;
              data_d  = shft_q;
              ferr_d  = !samp_i;
              noise_d = nacc_q;
              if (samp_i) begin
                state_d = ST_HUNT;
                idle_d  = I_FULL;
              end else begin
                state_d = ST_WAITHI;
              end
            end
          end
        end
        ST_WAITHI: begin
          if (samp_i) begin
            state_d = ST_HUNT;
            idle_d  = I_ONE;
          end
        end
        default: state_d = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      idle_q  <= '0;
      tcnt_q  <= T_ONE;
      bidx_q  <= '0;
      shft_q  <= '0;
      data_q  <= '0;
      pre_q   <= 1'b1;
      nacc_q  <= 1'b0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      noise_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idle_q  <= idle_d;
      tcnt_q  <= tcnt_d;
      bidx_q  <= bidx_d;
      shft_q  <= shft_d;
      data_q  <= data_d;
      pre_q   <= pre_d;
      nacc_q  <= nacc_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
      noise_q <= noise_d;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;
  assign noise_o = noise_q;

  // R2: a frame only opens from a full idle run and a low sample
  p_frame_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FRAME && $past(state_q) == ST_HUNT) |->
      ($past(idle_q) == I_FULL && !$past(samp_i) && $past(samp_vld_i)));
  // R5: single-clock strobe, only after a sample strobe, data held otherwise
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  p_valid_after_sample_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(samp_vld_i));
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> $stable(data_q));
  // R6: framing flag only with strobe; leaving the wait needs a high sample
  p_ferr_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_q |-> valid_q);
  p_waithi_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_WAITHI && state_q != ST_WAITHI) |-> $past(samp_i));
  // R7: noise flag only with strobe
  p_noise_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    noise_q |-> valid_q);
endmodule

// File: rtl/mcurx_top.sv
module mcurx_top #(
  parameter int NUM_CH   = 6,
  parameter int OSR      = 4,
  parameter int IDLE_RUN = 3,
  parameter bit VOTE_EN  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic [NUM_CH-1:0]    rx_i,
  output logic [NUM_CH*8-1:0]  rx_data_o,
  output logic [NUM_CH-1:0]    rx_valid_o,
  output logic [NUM_CH-1:0]    rx_ferr_o,
  output logic [NUM_CH-1:0]    rx_noise_o
);
  logic              rst_int_n;
  logic [NUM_CH-1:0] rx_sync;
  logic [NUM_CH-1:0] samp;
  logic              samp_vld;

  mcurx_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  mcurx_in_sync #(.W(NUM_CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  mcurx_capture #(.W(NUM_CH)) u_cap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .tick_i     (tick_i),
    .d_i        (rx_sync),
    .samp_o     (samp),
    .samp_vld_o (samp_vld)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mcurx_chan #(
      .OSR      (OSR),
      .IDLE_RUN (IDLE_RUN),
      .VOTE_EN  (VOTE_EN)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .samp_vld_i (samp_vld),
      .samp_i     (samp[g]),
      .data_o     (rx_data_o[g*8 +: 8]),
      .valid_o    (rx_valid_o[g]),
      .ferr_o     (rx_ferr_o[g]),
      .noise_o    (rx_noise_o[g])
    );
  end
endmodule

// File: tb/tb_mcurx_top.sv
`timescale 1ns/1ps
module tb_mcurx_top;
  localparam int NCH = 6;
  localparam int OSR = 4;
  localparam int CTR = (OSR + 1) / 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             tick;
  logic [NCH-1:0]   rx;
  logic [NCH*8-1:0] rx_data;
  logic [NCH-1:0]   rx_valid, rx_ferr, rx_noise;

  always #2.5 clk = ~clk;

  mcurx_top #(.NUM_CH(NCH), .OSR(OSR), .IDLE_RUN(3), .VOTE_EN(1'b1)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .rx_i       (rx),
    .rx_data_o  (rx_data),
    .rx_valid_o (rx_valid),
    .rx_ferr_o  (rx_ferr),
    .rx_noise_o (rx_noise)
  );

  typedef struct {
    logic [7:0] d;
    bit         fe;
    bit         nz;
    int         tk;
    bit         all;
  } exp_t;

  exp_t exq [NCH][$];
  bit   lv  [NCH][$];
  int   tick_cyc[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;
  bit   running = 1'b0;
  bit   done    = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_lvl(input int ch, input bit v, input int n);
    for (int i = 0; i < n; i++) lv[ch].push_back(v);
  endtask

  // nb: bit index (1..8 data) whose tick after centre is flipped, -1 none
  task automatic add_frame(input int ch, input logic [7:0] d, input bit bad,
                           input int nb, input bit all);
    exp_t e;
    e.d   = d;
    e.fe  = bad;
    e.nz  = (nb >= 0);
    e.tk  = lv[ch].size() + 9 * OSR + CTR - 1;
    e.all = all;
    exq[ch].push_back(e);
    for (int b = 0; b < 10; b++) begin
      bit level;
      level = (b == 0) ? 1'b0 : (b == 9) ? !bad : d[b-1];
      for (int t = 0; t < OSR; t++)
        lv[ch].push_back((b == nb && t == CTR) ? !level : level);
    end
  endtask

  task automatic align_all(input int extra);
    int mx;
    mx = 0;
    for (int c = 0; c < NCH; c++) if (lv[c].size() > mx) mx = lv[c].size();
    for (int c = 0; c < NCH; c++) add_lvl(c, 1'b1, mx - lv[c].size() + extra);
  endtask

  // monitor: compares every strobe with the expected frame list
  always @(negedge clk) begin
    if (running) begin
      for (int c = 0; c < NCH; c++) begin
        if (rx_valid[c]) begin
          if (exq[c].size() == 0) begin
            chk(1'b0, "R4", $sformatf("spurious byte ch%0d", c), rx_data[c*8 +: 8], 0);
          end else begin
            exp_t e;
            e = exq[c].pop_front();
            chk(rx_data[c*8 +: 8] == e.d, "R3", $sformatf("data ch%0d", c), rx_data[c*8 +: 8], e.d);
            chk(rx_ferr[c] == e.fe, "R6", $sformatf("framing flag ch%0d", c), rx_ferr[c], e.fe);
            chk(rx_noise[c] == e.nz, "R7", $sformatf("noise flag ch%0d", c), rx_noise[c], e.nz);
            chk(cyc == tick_cyc[e.tk] + 2, "R5", $sformatf("strobe cycle ch%0d", c), cyc, tick_cyc[e.tk] + 2);
            if (e.all) chk(rx_valid == '1, "R1", "simultaneous strobes", rx_valid, {NCH{1'b1}});
          end
        end else if (rx_ferr[c] || rx_noise[c]) begin
          chk(1'b0, "R6", $sformatf("flag without strobe ch%0d", c), {rx_ferr[c], rx_noise[c]}, 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int maxlen;
    bool_dummy();
    rst_n = 1'b0;
    tick  = 1'b0;
    rx    = '1;
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(rx_valid == '0, "R9", "valid in reset", rx_valid, 0);
    chk(rx_data == '0, "R9", "data in reset", rx_data, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(rx_valid == '0 && rx_ferr == '0 && rx_noise == '0, "R9", "flags after reset",
        {rx_valid, rx_ferr, rx_noise}, 0);
    chk(rx_data == '0, "R9", "data after reset", rx_data, 0);

    void'($urandom(32'h1D2C_3B4A));

    // directed corner cases
    add_lvl(0, 1'b1, 3);  add_frame(0, 8'hA5, 1'b0, -1, 1'b0);        // R2 exact idle run
    add_lvl(1, 1'b0, 10); add_lvl(1, 1'b1, 2);                         // R2 no start from reset low
    add_lvl(1, 1'b0, 12); add_lvl(1, 1'b1, 10);                        // R2 short idle run
    add_lvl(2, 1'b1, 4);  add_lvl(2, 1'b0, 1); add_lvl(2, 1'b1, 5);    // R4 glitch start
    add_frame(2, 8'h3C, 1'b0, -1, 1'b0);
    add_lvl(3, 1'b1, 4);  add_frame(3, 8'h81, 1'b1, -1, 1'b0);         // R6 bad stop
    add_lvl(3, 1'b0, 8);  add_lvl(3, 1'b1, 4);
    add_frame(3, 8'h7E, 1'b0, -1, 1'b0);
    add_lvl(4, 1'b1, 4);  add_frame(4, 8'h55, 1'b0, 3, 1'b0);          // R7 noisy bit
    add_frame(4, 8'hAA, 1'b0, -1, 1'b0);                               // R8 back to back
    add_lvl(5, 1'b1, 4);  add_frame(5, 8'h00, 1'b0, -1, 1'b0);
    add_lvl(5, 1'b1, 1);  add_frame(5, 8'hFF, 1'b0, -1, 1'b0);         // R10 odd gap
    align_all(4);
    for (int c = 0; c < NCH; c++) add_frame(c, 8'hC3, 1'b0, -1, 1'b1); // R1 same instant
    align_all(4);

    // random traffic (R3, R6, R7, R8, R10)
    for (int c = 0; c < NCH; c++) begin
      bit prev_bad;
      prev_bad = 1'b0;
      for (int f = 0; f < 25; f++) begin
        int  gap;
        bit  bad;
        int  nb;
        gap = prev_bad ? 3 + $urandom_range(0, 5) : $urandom_range(0, 6);
        add_lvl(c, 1'b1, gap);
        bad = ($urandom_range(0, 7) == 0);
        nb  = ($urandom_range(0, 5) == 0) ? $urandom_range(1, 8) : -1;
        add_frame(c, 8'($urandom), bad, nb, 1'b0);
        prev_bad = bad;
      end
    end
    align_all(20);

    maxlen = lv[0].size();
    running = 1'b1;
    for (int k = 0; k < maxlen; k++) begin
      @(negedge clk);
      tick = 1'b0;
      for (int c = 0; c < NCH; c++) rx[c] = lv[c][k];
      repeat (3) @(negedge clk);
      tick = 1'b1;
      tick_cyc.push_back(cyc);
    end
    @(negedge clk);
    tick = 1'b0;
    repeat (10) @(negedge clk);
    running = 1'b0;
    for (int c = 0; c < NCH; c++)
      chk(exq[c].size() == 0, "R5", $sformatf("missing bytes ch%0d", c), exq[c].size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic bool_dummy();
  endtask
endmodule